// File: doc/BRIEF.md
# Endpoint Freeze Filter Table

This block holds the error-isolation state for every partitionable endpoint behind one host bridge. Each endpoint number owns an entry with two freeze flags, one gating the memory-mapped I/O path and one gating the DMA path, and a small syndrome: a cause code and the address of the offending access. A detected error, or a write from software, freezes an entry. Both flags go up in the same cycle. Software can then release either path on its own.

In the transaction path, the block takes an endpoint number and a transaction kind and returns a verdict one cycle later. The verdict is pass, drop or fill. A frozen endpoint has its stores and MSIs dropped. Its loads are answered with a synthesized all-ones data word. A registered read port lets software see both flags and the captured syndrome of any entry. The syndrome records only the first freeze of an episode, so a burst of follow-on errors cannot overwrite the original cause.

Top module: `pe_freeze_filter`

## Requirements
- R1: After reset every entry reads back with both flags clear, cause 0 and address 0, and every transaction passes.
- R2: A hardware freeze (`frz_valid`) of an entry sets both its MMIO flag and its DMA flag at the same clock edge.
- R3: A software clear (`sw_clr_valid`) clears the MMIO flag when `sw_clr_mmio` is 1 and the DMA flag when `sw_clr_dma` is 1. A flag that is not selected keeps its value.
- R4: When a freeze (hardware or software) and a software clear target the same entry in the same cycle, both flags end up set.
- R5: Kind codes: 0 MMIO load, 1 MMIO store, 2 DMA read, 3 DMA write, 4 MSI, 5 to 7 unused. An MMIO store to an entry whose MMIO flag is set, or a DMA write from an entry whose DMA flag is set, gets verdict code 1 (drop).
- R6: An MMIO load with the MMIO flag set, or a DMA read with the DMA flag set, gets verdict code 2 (fill), and `resp_data` is all ones.
- R7: An MSI from an entry whose DMA flag is set gets verdict code 1 (drop). The MMIO flag has no effect on MSIs.
- R8: MMIO kinds consult only the MMIO flag, and DMA kinds and MSIs consult only the DMA flag. When the consulted flag is clear, or the kind code is unused, the verdict is code 0 (pass) with `resp_data` zero.
- R9: A freeze captures cause and address only when the entry had both flags clear beforehand. Otherwise the stored syndrome is unchanged. It stays readable after the flags are cleared, until the next first freeze.
- R10: A software freeze (`sw_frz_valid`) sets both flags and captures cause all-ones and address zero. If a hardware freeze hits the same entry in the same cycle, the hardware cause and address are captured instead.
- R11: `resp_valid` and the verdict appear one cycle after `txn_valid` and reflect the flags as they stood at the start of the request cycle. The read port likewise returns, one cycle after `rd_pe`, the state at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction lookup request |
| txn_pe | input | PE_W | Endpoint number of the transaction |
| txn_kind | input | 3 | Transaction kind code (R5) |
| frz_valid | input | 1 | Hardware freeze request |
| frz_pe | input | PE_W | Endpoint to freeze |
| frz_cause | input | CAUSE_W | Cause code of the freeze |
| frz_addr | input | ADDR_W | Address of the offending access |
| sw_frz_valid | input | 1 | Software freeze request |
| sw_frz_pe | input | PE_W | Endpoint for the software freeze |
| sw_clr_valid | input | 1 | Software clear request |
| sw_clr_pe | input | PE_W | Endpoint to clear |
| sw_clr_mmio | input | 1 | Clear the MMIO flag |
| sw_clr_dma | input | 1 | Clear the DMA flag |
| rd_pe | input | PE_W | Endpoint for the status read port |
| resp_valid | output | 1 | Verdict valid |
| resp_code | output | 2 | Verdict: 0 pass, 1 drop, 2 fill |
| resp_data | output | DATA_W | All ones on fill, zero otherwise |
| rd_mmio_frz | output | 1 | MMIO flag of the read entry |
| rd_dma_frz | output | 1 | DMA flag of the read entry |
| rd_cause | output | CAUSE_W | Captured cause of the read entry |
| rd_addr | output | ADDR_W | Captured address of the read entry |

## Verification
A flag stuck in the wrong state shows up at the next transaction for that endpoint. The bad flag gives a wrong verdict code one cycle after the request, or it shows on the read port one cycle after that entry is selected. If the syndrome is overwritten by a second freeze, or is not captured on the first, the mismatch appears on `rd_cause`/`rd_addr` the first time software reads the entry, even long after the event. Colliding freezes and clears on a small set of endpoints exercise the priority rules. Comparing the model every cycle catches a wrong flag within two cycles of it being touched.

// File: rtl/pe_frz_pkg.sv
package pe_frz_pkg;

   typedef enum logic [2:0] {
      K_MMIO_LD = 3'd0,
      K_MMIO_ST = 3'd1,
      K_DMA_RD  = 3'd2,
      K_DMA_WR  = 3'd3,
      K_MSI     = 3'd4
   } txn_kind_e;

   typedef enum logic [1:0] {
      V_PASS = 2'd0,
      V_DROP = 2'd1,
      V_FILL = 2'd2
   } verdict_e;

endpackage

// File: rtl/pe_frz_entry.sv
// One endpoint's freeze flags and first-error syndrome.
module pe_frz_entry #(
   parameter int CAUSE_W = 4,
   parameter int ADDR_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hw_hit,
   input  logic [CAUSE_W-1:0] hw_cause,
   input  logic [ADDR_W-1:0]  hw_addr,
   input  logic               sw_set_hit,
   input  logic               clr_hit,
   input  logic               clr_mmio,
   input  logic               clr_dma,
   output logic               mmio_frz,
   output logic               dma_frz,
   output logic [CAUSE_W-1:0] syn_cause,
   output logic [ADDR_W-1:0]  syn_addr
);
   localparam logic [CAUSE_W-1:0] SW_CAUSE = '1;

   logic set_any;
   logic first_frz;
   logic mmio_nxt, dma_nxt;

   assign set_any   = hw_hit | sw_set_hit;
   assign first_frz = set_any & ~mmio_frz & ~dma_frz;

   // A freeze outranks a same-cycle clear.
   always_comb begin
      mmio_nxt = mmio_frz;
      dma_nxt  = dma_frz;
      if (clr_hit && clr_mmio) mmio_nxt = 1'b0;
      if (clr_hit && clr_dma)  dma_nxt  = 1'b0;
      if (set_any) begin
         mmio_nxt = 1'b1;
         dma_nxt  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mmio_frz <= 1'b0;
         dma_frz  <= 1'b0;
      end else begin
         mmio_frz <= mmio_nxt;
         dma_frz  <= dma_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_cause <= '0;
         syn_addr  <= '0;
      end else if (first_frz) begin
         syn_cause <= hw_hit ? hw_cause : SW_CAUSE;
         syn_addr  <= hw_hit ? hw_addr  : '0;
      end
   end
endmodule

// File: rtl/pe_frz_verdict.sv
// Registered pass / drop / fill decision for one transaction.
module pe_frz_verdict
   import pe_frz_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit MSI_ON_DMA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic              mmio_bit,
   input  logic              dma_bit,
   output logic              resp_valid,
   output logic [1:0]        resp_code,
   output logic [DATA_W-1:0] resp_data
);
   logic     msi_gate;
   verdict_e code_nxt;

   generate
      if (MSI_ON_DMA) begin : g_msi_dma
         assign msi_gate = dma_bit;
      end else begin : g_msi_mmio
         assign msi_gate = mmio_bit;
      end
   endgenerate

   always_comb begin
      code_nxt = V_PASS;
      unique case (req_kind)
         K_MMIO_LD: code_nxt = mmio_bit ? V_FILL : V_PASS;
         K_MMIO_ST: code_nxt = mmio_bit ? V_DROP : V_PASS;
         K_DMA_RD:  code_nxt = dma_bit  ? V_FILL : V_PASS;
         K_DMA_WR:  code_nxt = dma_bit  ? V_DROP : V_PASS;
         K_MSI:     code_nxt = msi_gate ? V_DROP : V_PASS;
         default:   code_nxt = V_PASS;
      endcase
      if (!req_valid) code_nxt = V_PASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_code  <= V_PASS;
         resp_data  <= '0;
      end else begin
         resp_valid <= req_valid;
         resp_code  <= code_nxt;
         resp_data  <= (code_nxt == V_FILL) ? '1 : '0;
      end
   end
endmodule

// File: rtl/pe_frz_readport.sv
// Registered status read of one entry.
module pe_frz_readport #(
   parameter int NUM_PE  = 256,
   parameter int PE_W    = 8,
   parameter int CAUSE_W = 4,
   parameter int ADDR_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PE_W-1:0]    sel_pe,
   input  logic [NUM_PE-1:0]  mmio_vec,
   input  logic [NUM_PE-1:0]  dma_vec,
   input  logic [CAUSE_W-1:0] cause_arr [NUM_PE],
   input  logic [ADDR_W-1:0]  addr_arr  [NUM_PE],
   output logic               out_mmio,
   output logic               out_dma,
   output logic [CAUSE_W-1:0] out_cause,
   output logic [ADDR_W-1:0]  out_addr
);
   logic in_range;
   assign in_range = (int'(sel_pe) < NUM_PE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_mmio  <= 1'b0;
         out_dma   <= 1'b0;
         out_cause <= '0;
         out_addr  <= '0;
      end else if (in_range) begin
         out_mmio  <= mmio_vec[sel_pe];
         out_dma   <= dma_vec[sel_pe];
         out_cause <= cause_arr[sel_pe];
         out_addr  <= addr_arr[sel_pe];
      end else begin
         out_mmio  <= 1'b0;
         out_dma   <= 1'b0;
         out_cause <= '0;
         out_addr  <= '0;
      end
   end
endmodule

// File: rtl/pe_freeze_filter.sv
module pe_freeze_filter #(
   parameter int NUM_PE     = 256,
   parameter int CAUSE_W    = 4,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit MSI_ON_DMA = 1'b1,
   localparam int PE_W      = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               txn_valid,
   input  logic [PE_W-1:0]    txn_pe,
   input  logic [2:0]         txn_kind,
   input  logic               frz_valid,
   input  logic [PE_W-1:0]    frz_pe,
   input  logic [CAUSE_W-1:0] frz_cause,
   input  logic [ADDR_W-1:0]  frz_addr,
   input  logic               sw_frz_valid,
   input  logic [PE_W-1:0]    sw_frz_pe,
   input  logic               sw_clr_valid,
   input  logic [PE_W-1:0]    sw_clr_pe,
   input  logic               sw_clr_mmio,
   input  logic               sw_clr_dma,
   input  logic [PE_W-1:0]    rd_pe,
   output logic               resp_valid,
   output logic [1:0]         resp_code,
   output logic [DATA_W-1:0]  resp_data,
   output logic               rd_mmio_frz,
   output logic               rd_dma_frz,
   output logic [CAUSE_W-1:0] rd_cause,
   output logic [ADDR_W-1:0]  rd_addr
);
   generate
      if (NUM_PE < 2 || NUM_PE > 1024) begin : g_bad_num_pe
         $error("pe_freeze_filter: NUM_PE must lie in 2..1024");
      end
      if (CAUSE_W < 1 || CAUSE_W > 16) begin : g_bad_cause_w
         $error("pe_freeze_filter: CAUSE_W must lie in 1..16");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_widths
         $error("pe_freeze_filter: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [NUM_PE-1:0]  mmio_vec;
   logic [NUM_PE-1:0]  dma_vec;
   logic [CAUSE_W-1:0] cause_arr [NUM_PE];
   logic [ADDR_W-1:0]  addr_arr  [NUM_PE];

   generate
      for (genvar g = 0; g < NUM_PE; g++) begin : g_ent
         logic hw_hit, sw_hit, clr_hit;
         assign hw_hit  = frz_valid    && (frz_pe    == PE_W'(g));
         assign sw_hit  = sw_frz_valid && (sw_frz_pe == PE_W'(g));
         assign clr_hit = sw_clr_valid && (sw_clr_pe == PE_W'(g));

         pe_frz_entry #(
            .CAUSE_W (CAUSE_W),
            .ADDR_W  (ADDR_W)
         ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_hit     (hw_hit),
            .hw_cause   (frz_cause),
            .hw_addr    (frz_addr),
            .sw_set_hit (sw_hit),
            .clr_hit    (clr_hit),
            .clr_mmio   (sw_clr_mmio),
            .clr_dma    (sw_clr_dma),
            .mmio_frz   (mmio_vec[g]),
            .dma_frz    (dma_vec[g]),
            .syn_cause  (cause_arr[g]),
            .syn_addr   (addr_arr[g])
         );
      end
   endgenerate

   logic txn_in_range;
   logic txn_mmio_bit, txn_dma_bit;

   assign txn_in_range = (int'(txn_pe) < NUM_PE);
   assign txn_mmio_bit = txn_in_range ? mmio_vec[txn_pe] : 1'b0;
   assign txn_dma_bit  = txn_in_range ? dma_vec[txn_pe]  : 1'b0;

   pe_frz_verdict #(
      .DATA_W     (DATA_W),
      .MSI_ON_DMA (MSI_ON_DMA)
   ) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (txn_valid),
      .req_kind   (txn_kind),
      .mmio_bit   (txn_mmio_bit),
      .dma_bit    (txn_dma_bit),
      .resp_valid (resp_valid),
      .resp_code  (resp_code),
      .resp_data  (resp_data)
   );

   pe_frz_readport #(
      .NUM_PE  (NUM_PE),
      .PE_W    (PE_W),
      .CAUSE_W (CAUSE_W),
      .ADDR_W  (ADDR_W)
   ) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_pe    (rd_pe),
      .mmio_vec  (mmio_vec),
      .dma_vec   (dma_vec),
      .cause_arr (cause_arr),
      .addr_arr  (addr_arr),
      .out_mmio  (rd_mmio_frz),
      .out_dma   (rd_dma_frz),
      .out_cause (rd_cause),
      .out_addr  (rd_addr)
   );
endmodule

// File: rtl/pe_freeze_filter_chk.sv
module pe_freeze_filter_chk #(
   parameter int NUM_PE  = 256,
   parameter int CAUSE_W = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int PE_W    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               txn_valid,
   input logic [PE_W-1:0]    frz_pe,
   input logic               frz_valid,
   input logic               sw_frz_valid,
   input logic [PE_W-1:0]    sw_frz_pe,
   input logic [PE_W-1:0]    rd_pe,
   input logic               resp_valid,
   input logic [1:0]         resp_code,
   input logic [DATA_W-1:0]  resp_data,
   input logic               rd_mmio_frz,
   input logic               rd_dma_frz
);
   assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> resp_valid);

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !resp_valid);

   assert_fill_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 2'd2) |-> (resp_data == '1));

   assert_nonfill_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code != 2'd2) |-> (resp_data == '0));

   assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_code != 2'd3);

   // R2 and R4: a freeze sets both flags, even against a same-cycle clear.
   assert_hw_freeze_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(frz_valid) && rd_pe == $past(frz_pe))
      |=> (rd_mmio_frz && rd_dma_frz));

   assert_sw_freeze_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sw_frz_valid) && rd_pe == $past(sw_frz_pe))
      |=> (rd_mmio_frz && rd_dma_frz));
endmodule

bind pe_freeze_filter pe_freeze_filter_chk #(
   .NUM_PE  (NUM_PE),
   .CAUSE_W (CAUSE_W),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .PE_W    (PE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .txn_valid    (txn_valid),
   .frz_pe       (frz_pe),
   .frz_valid    (frz_valid),
   .sw_frz_valid (sw_frz_valid),
   .sw_frz_pe    (sw_frz_pe),
   .rd_pe        (rd_pe),
   .resp_valid   (resp_valid),
   .resp_code    (resp_code),
   .resp_data    (resp_data),
   .rd_mmio_frz  (rd_mmio_frz),
   .rd_dma_frz   (rd_dma_frz)
);

// File: tb/pe_freeze_filter_tb.sv
`timescale 1ns/1ps
module pe_freeze_filter_tb;
   localparam int NPE = 256;
   localparam int PW  = 8;
   localparam int CW  = 4;
   localparam int AW  = 32;
   localparam int DW  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_valid = 1'b0;
   logic [PW-1:0] txn_pe = '0;
   logic [2:0] txn_kind = '0;
   logic frz_valid = 1'b0;
   logic [PW-1:0] frz_pe = '0;
   logic [CW-1:0] frz_cause = '0;
   logic [AW-1:0] frz_addr = '0;
   logic sw_frz_valid = 1'b0;
   logic [PW-1:0] sw_frz_pe = '0;
   logic sw_clr_valid = 1'b0;
   logic [PW-1:0] sw_clr_pe = '0;
   logic sw_clr_mmio = 1'b0;
   logic sw_clr_dma = 1'b0;
   logic [PW-1:0] rd_pe = '0;
   logic resp_valid;
   logic [1:0] resp_code;
   logic [DW-1:0] resp_data;
   logic rd_mmio_frz, rd_dma_frz;
   logic [CW-1:0] rd_cause;
   logic [AW-1:0] rd_addr;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pe_freeze_filter #(.NUM_PE(NPE), .CAUSE_W(CW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_pe(txn_pe), .txn_kind(txn_kind),
      .frz_valid(frz_valid), .frz_pe(frz_pe), .frz_cause(frz_cause), .frz_addr(frz_addr),
      .sw_frz_valid(sw_frz_valid), .sw_frz_pe(sw_frz_pe), .sw_clr_valid(sw_clr_valid),
      .sw_clr_pe(sw_clr_pe), .sw_clr_mmio(sw_clr_mmio), .sw_clr_dma(sw_clr_dma), .rd_pe(rd_pe),
      .resp_valid(resp_valid), .resp_code(resp_code), .resp_data(resp_data),
      .rd_mmio_frz(rd_mmio_frz), .rd_dma_frz(rd_dma_frz), .rd_cause(rd_cause), .rd_addr(rd_addr));

   // ---------------- behavioural reference model ----------------
   bit m_mm [NPE];
   bit m_dm [NPE];
   int m_cause [NPE];
   longint m_addr [NPE];
   bit armed = 0;
   bit e_valid;
   int e_code;
   longint e_data;
   bit e_rm, e_rd;
   int e_cause;
   longint e_addr;
   string e_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPE; i++) begin
            m_mm[i] = 0; m_dm[i] = 0; m_cause[i] = 0; m_addr[i] = 0;
         end
         armed = 0;
      end else begin
         int k;
         bit flag, hcap, scap;
         int fp, sp, cp;
         k = int'(txn_kind);
         flag = (k <= 1) ? m_mm[txn_pe] : m_dm[txn_pe];
         e_valid = txn_valid;
         e_code = 0; e_tag = "R8";
         if (txn_valid && k <= 4 && flag) begin
            if (k == 0 || k == 2) begin e_code = 2; e_tag = "R6"; end
            else if (k == 4) begin e_code = 1; e_tag = "R7"; end
            else begin e_code = 1; e_tag = "R5"; end
         end
         e_data = (e_code == 2) ? 64'hFFFF_FFFF : 0;
         e_rm = m_mm[rd_pe]; e_rd = m_dm[rd_pe];
         e_cause = m_cause[rd_pe]; e_addr = m_addr[rd_pe];
         fp = int'(frz_pe); sp = int'(sw_frz_pe); cp = int'(sw_clr_pe);
         hcap = frz_valid && !m_mm[fp] && !m_dm[fp];
         scap = sw_frz_valid && !m_mm[sp] && !m_dm[sp] && !(frz_valid && fp == sp);
         if (sw_clr_valid && sw_clr_mmio) m_mm[cp] = 0;
         if (sw_clr_valid && sw_clr_dma)  m_dm[cp] = 0;
         if (frz_valid)    begin m_mm[fp] = 1; m_dm[fp] = 1; end
         if (sw_frz_valid) begin m_mm[sp] = 1; m_dm[sp] = 1; end
         if (hcap) begin m_cause[fp] = int'(frz_cause); m_addr[fp] = longint'(frz_addr); end
         if (scap) begin m_cause[sp] = 15; m_addr[sp] = 0; end
         armed = 1;
      end
   end

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && armed && !done) begin
         chk("R11", longint'(resp_valid), longint'(e_valid));
         if (e_valid) begin
            chk(e_tag, longint'(resp_code), longint'(e_code));
            chk(e_tag, longint'(resp_data), e_data);
         end
         chk("R2", longint'(rd_mmio_frz), longint'(e_rm));
         chk("R3", longint'(rd_dma_frz), longint'(e_rd));
         chk("R9", longint'(rd_cause), longint'(e_cause));
         chk("R9", longint'(rd_addr), e_addr);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      txn_valid = 0; frz_valid = 0; sw_frz_valid = 0; sw_clr_valid = 0;
      sw_clr_mmio = 0; sw_clr_dma = 0;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // Select rd_pe, wait one edge, then compare the read port directly.
   task automatic read_chk(string req, int pe, bit em, bit ed, int ec, longint ea);
      idle(); rd_pe = PW'(pe);
      cyc();
      chk(req, longint'(rd_mmio_frz), longint'(em));
      chk(req, longint'(rd_dma_frz), longint'(ed));
      chk(req, longint'(rd_cause), longint'(ec));
      chk(req, longint'(rd_addr), ea);
   endtask

   task automatic txn_chk(string req, int pe, int kind, int ecode);
      idle(); txn_valid = 1; txn_pe = PW'(pe); txn_kind = 3'(kind);
      cyc();
      txn_valid = 0;
      chk(req, longint'(resp_code), longint'(ecode));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) cyc();
      rst_n = 1;
      cyc();
      // R1: reset state
      read_chk("R1", 0, 0, 0, 0, 0);
      read_chk("R1", 255, 0, 0, 0, 0);
      for (int k = 0; k < 5; k++) txn_chk("R8", 3, k, 0);

      // R2 / R9: first hardware freeze captures syndrome
      idle(); frz_valid = 1; frz_pe = 3; frz_cause = 5; frz_addr = 32'h0000_1234;
      txn_valid = 1; txn_pe = 3; txn_kind = 0;   // R11: same-cycle request sees old state
      cyc();
      idle();
      chk("R11", longint'(resp_code), 0);
      read_chk("R2", 3, 1, 1, 5, 32'h1234);
      txn_chk("R6", 3, 0, 2);
      chk("R6", longint'(resp_data), 64'hFFFF_FFFF);
      txn_chk("R5", 3, 1, 1);
      txn_chk("R6", 3, 2, 2);
      txn_chk("R5", 3, 3, 1);
      txn_chk("R7", 3, 4, 1);
      txn_chk("R8", 3, 6, 0);
      txn_chk("R8", 4, 0, 0);

      // R9: a second freeze leaves the syndrome alone
      idle(); frz_valid = 1; frz_pe = 3; frz_cause = 7; frz_addr = 32'hDEAD_0000;
      cyc();
      read_chk("R9", 3, 1, 1, 5, 32'h1234);

      // R3: clear only the MMIO flag
      idle(); sw_clr_valid = 1; sw_clr_pe = 3; sw_clr_mmio = 1;
      cyc();
      read_chk("R3", 3, 0, 1, 5, 32'h1234);
      txn_chk("R8", 3, 0, 0);
      txn_chk("R8", 3, 1, 0);
      txn_chk("R7", 3, 4, 1);
      txn_chk("R6", 3, 2, 2);

      // R3: clear the DMA flag; syndrome still held (R9)
      idle(); sw_clr_valid = 1; sw_clr_pe = 3; sw_clr_dma = 1;
      cyc();
      read_chk("R9", 3, 0, 0, 5, 32'h1234);
      txn_chk("R8", 3, 3, 0);

      // R9: new episode captures afresh
      idle(); frz_valid = 1; frz_pe = 3; frz_cause = 2; frz_addr = 32'h00AB_CDEF;
      cyc();
      read_chk("R9", 3, 1, 1, 2, 32'h00AB_CDEF);

      // R7: MMIO flag alone does not block an MSI
      idle(); sw_clr_valid = 1; sw_clr_pe = 3; sw_clr_dma = 1;
      cyc();
      txn_chk("R7", 3, 4, 0);
      txn_chk("R6", 3, 0, 2);

      // R4: freeze and clear on the same entry, same cycle
      idle(); frz_valid = 1; frz_pe = 10; frz_cause = 9; frz_addr = 32'h10;
      sw_clr_valid = 1; sw_clr_pe = 10; sw_clr_mmio = 1; sw_clr_dma = 1;
      cyc();
      read_chk("R4", 10, 1, 1, 9, 32'h10);

      // R10: software freeze
      idle(); sw_frz_valid = 1; sw_frz_pe = 20;
      cyc();
      read_chk("R10", 20, 1, 1, 15, 0);
      // R10: software and hardware together, hardware syndrome wins
      idle(); sw_frz_valid = 1; sw_frz_pe = 21; frz_valid = 1; frz_pe = 21;
      frz_cause = 4; frz_addr = 32'h5555_0000;
      cyc();
      read_chk("R10", 21, 1, 1, 4, 32'h5555_0000);
      // R4: software freeze against a clear
      idle(); sw_frz_valid = 1; sw_frz_pe = 22; sw_clr_valid = 1; sw_clr_pe = 22;
      sw_clr_mmio = 1; sw_clr_dma = 1;
      cyc();
      read_chk("R4", 22, 1, 1, 15, 0);

      // Mixed traffic on a small set of entries, compared with the model
      for (int n = 0; n < 4000; n++) begin
         txn_valid = 1'($urandom_range(1));
         txn_pe = PW'($urandom_range(7));
         txn_kind = 3'($urandom_range(7));
         frz_valid = ($urandom_range(9) == 0);
         frz_pe = PW'($urandom_range(7));
         frz_cause = CW'($urandom);
         frz_addr = AW'($urandom);
         sw_frz_valid = ($urandom_range(15) == 0);
         sw_frz_pe = PW'($urandom_range(7));
         sw_clr_valid = ($urandom_range(3) == 0);
         sw_clr_pe = PW'($urandom_range(7));
         sw_clr_mmio = 1'($urandom_range(1));
         sw_clr_dma = 1'($urandom_range(1));
         rd_pe = PW'($urandom_range(7));
         cyc();
      end
      idle();
      cyc(); cyc();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule